// File: doc/BRIEF.md
# Processor-Side Mailbox Register File

This block sits between a 32-bit processor bus and the byte-oriented engine of an I2C slave. It holds two small mailboxes of 32-bit words. The outbound mailbox is loaded by the processor, and the I2C engine reads it back one byte at a time. The inbound mailbox is filled one byte at a time by the I2C engine and is read-only to the processor.

Two interrupt lines coordinate the transfer. The external line tells the I2C master that fresh outbound data is waiting. It is raised by any processor write to outbound word 0. For that reason, software loads words 1 and 2 first and writes word 0 last. The line drops once the engine reports a completed read transaction addressed to this slave. The processor line pulses when the engine stores the configured last inbound byte.

The processor side uses a valid/ready handshake with a byte address. The two low address bits are ignored.

Top module: `mbx_regfile`

## Requirements
- R1: While reset is asserted and after it is released, all six words read 0, `bus_ready`, `ext_irq` and `proc_irq` are 0, and `eng_rd_data` is 0.
- R2: When `bus_valid` is high and `bus_ready` is low at a clock edge, that edge accepts the access. `bus_ready` is high for exactly the following cycle, and `bus_rdata` holds the read data in that cycle. The master drops `bus_valid` before the next edge.
- R3: Word addresses 0x00, 0x04 and 0x08 are outbound words 0, 1 and 2. Each can be read and written with full 32-bit data.
- R4: A write to 0x00 sets `ext_irq` at the accepting edge. Writes to 0x04 and 0x08 leave `ext_irq` unchanged.
- R5: `ext_irq` clears at the edge where `eng_read_done` is high. It holds its value otherwise. If a write to 0x00 is accepted at that same edge, the set wins.
- R6: Addresses 0x0C, 0x10 and 0x14 hold inbound words 0, 1 and 2. Writes to these addresses are acknowledged and change nothing.
- R7: An engine write with `eng_wr_idx` = k stores `eng_wr_data` in inbound word k/4, bits 8*(k%4)+7 down to 8*(k%4). Indexes 0 to 11 are valid.
- R8: `proc_irq` is high for the single cycle after an engine write to byte index INT_BYTES-1 (default 11). Engine writes to any other index leave it low.
- R9: Reads of addresses 0x18 and above return 0.
- R10: `eng_rd_data` shows, combinationally, outbound byte `eng_rd_idx` using the same byte mapping as R7. Indexes 12 and above read 0.
- R11: Processor reads never alter inbound or outbound contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | One-cycle acknowledge |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| eng_wr_en | input | 1 | Engine stores one inbound byte |
| eng_wr_idx | input | IDX_W | Inbound byte index |
| eng_wr_data | input | 8 | Inbound byte value |
| eng_rd_idx | input | IDX_W | Outbound byte index |
| eng_rd_data | output | 8 | Outbound byte value |
| eng_read_done | input | 1 | Engine finished a read transaction to this slave |
| ext_irq | output | 1 | Interrupt toward the I2C master |
| proc_irq | output | 1 | Interrupt pulse toward the processor |

## Verification
Bus results become visible one edge after acceptance. `bus_ready`, `bus_rdata` and the doorbell setting of `ext_irq` all appear after that edge, so the bench samples them on the falling edge that follows. The bench then confirms that `bus_ready` has dropped one edge later. An engine byte write and its `proc_irq` pulse, and the clearing of `ext_irq` by `eng_read_done`, are both checked on the falling edge after the single edge that registers them. `eng_rd_data` has no register in its path and is sampled in the same half-cycle in which its index is driven.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned WORD_W         = 32;
  localparam int unsigned BYTE_W         = 8;
  localparam int unsigned BYTES_PER_WORD = WORD_W / BYTE_W;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_OUT  = 2'd1,
    REG_IN   = 2'd2
  } region_e;
endpackage

// File: rtl/mbx_bus_decode.sv
module mbx_bus_decode
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned N_OUT  = 3,
  parameter int unsigned N_IN   = 3,
  parameter int unsigned SLOT_W = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [SLOT_W-1:0] slot_o
);
  localparam int unsigned WORD_AW = ADDR_W - 2;

  logic [WORD_AW-1:0] word_idx;
  logic [WORD_AW-1:0] in_off;

  assign word_idx = addr_i[ADDR_W-1:2];
  assign in_off   = word_idx - WORD_AW'(N_OUT);

  always_comb begin
    region_o = REG_NONE;
    slot_o   = '0;
    if (word_idx < WORD_AW'(N_OUT)) begin
      region_o = REG_OUT;
      slot_o   = word_idx[SLOT_W-1:0];
    end else if (word_idx < WORD_AW'(N_OUT + N_IN)) begin
      region_o = REG_IN;
      slot_o   = in_off[SLOT_W-1:0];
    end
  end
endmodule

// File: rtl/mbx_out_bank.sv
module mbx_out_bank
  import mbx_pkg::*;
#(
  parameter int unsigned N_OUT  = 3,
  parameter int unsigned SLOT_W = 3,
  parameter int unsigned IDX_W  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we_i,
  input  logic [SLOT_W-1:0]            slot_i,
  input  logic [WORD_W-1:0]            wdata_i,
  output logic [N_OUT-1:0][WORD_W-1:0] words_o,
  input  logic [IDX_W-1:0]             rd_idx_i,
  output logic [BYTE_W-1:0]            rd_byte_o
);
  localparam int unsigned N_BYTES = N_OUT * BYTES_PER_WORD;

  logic [N_OUT-1:0][WORD_W-1:0]  word_q;
  logic [N_BYTES-1:0][BYTE_W-1:0] byte_view;

  for (genvar w = 0; w < N_OUT; w++) begin : g_word
    logic load;
    assign load = we_i && (slot_i == SLOT_W'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    word_q[w] <= '0;
      else if (load) word_q[w] <= wdata_i;
    end
  end

  assign words_o   = word_q;
  assign byte_view = word_q;

  always_comb begin
    rd_byte_o = '0;
    for (int b = 0; b < int'(N_BYTES); b++) begin
      if (rd_idx_i == IDX_W'(b)) rd_byte_o = byte_view[b];
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(word_q)); // R6
endmodule

// File: rtl/mbx_in_bank.sv
module mbx_in_bank
  import mbx_pkg::*;
#(
  parameter int unsigned N_IN      = 3,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned INT_BYTES = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en_i,
  input  logic [IDX_W-1:0]            wr_idx_i,
  input  logic [BYTE_W-1:0]           wr_data_i,
  output logic [N_IN-1:0][WORD_W-1:0] words_o,
  output logic                        irq_o
);
  localparam int unsigned N_BYTES  = N_IN * BYTES_PER_WORD;
  localparam int unsigned LAST_IDX = INT_BYTES - 1;

  logic [N_BYTES-1:0][BYTE_W-1:0] byte_q;
  logic                           irq_d;
  logic                           irq_q;

  for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
    logic load;
    assign load = wr_en_i && (wr_idx_i == IDX_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    byte_q[b] <= '0;
      else if (load) byte_q[b] <= wr_data_i;
    end
  end

  always_comb irq_d = wr_en_i && (wr_idx_i == IDX_W'(LAST_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign words_o = byte_q;
  assign irq_o   = irq_q;

  AST_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(byte_q)); // R11
  AST_PIRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(wr_en_i)); // R8
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  logic irq_d;
  logic irq_q;

  always_comb begin
    irq_d = irq_q;
    if (clr_i) irq_d = 1'b0;
    if (set_i) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  AST_DB_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> irq_o); // R4
  AST_DB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !irq_o); // R5
  AST_DB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(irq_o)); // R5
endmodule

// File: rtl/mbx_regfile.sv
module mbx_regfile
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned N_OUT     = 3,
  parameter int unsigned N_IN      = 3,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned INT_BYTES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_ready,
  output logic [31:0]       bus_rdata,
  input  logic              eng_wr_en,
  input  logic [IDX_W-1:0]  eng_wr_idx,
  input  logic [7:0]        eng_wr_data,
  input  logic [IDX_W-1:0]  eng_rd_idx,
  output logic [7:0]        eng_rd_data,
  input  logic              eng_read_done,
  output logic              ext_irq,
  output logic              proc_irq
);
  localparam int unsigned SLOT_W = (N_OUT + N_IN > 1) ? $clog2(N_OUT + N_IN) : 1;

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  region_e                      region;
  logic [SLOT_W-1:0]            slot;
  logic [N_OUT-1:0][WORD_W-1:0] out_words;
  logic [N_IN-1:0][WORD_W-1:0]  in_words;
  logic                         accept;
  logic                         out_we;
  logic                         db_set;
  logic [WORD_W-1:0]            rd_mux;
  logic                         ready_d;
  logic                         ready_q;
  logic [WORD_W-1:0]            rdata_d;
  logic [WORD_W-1:0]            rdata_q;

  mbx_bus_decode #(
    .ADDR_W (ADDR_W),
    .N_OUT  (N_OUT),
    .N_IN   (N_IN),
    .SLOT_W (SLOT_W)
  ) u_decode (
    .addr_i   (bus_addr),
    .region_o (region),
    .slot_o   (slot)
  );

  assign accept = bus_valid && !ready_q;
  assign out_we = accept && bus_write && (region == REG_OUT);
  assign db_set = out_we && (slot == '0);

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < int'(N_OUT); w++) begin
      if (region == REG_OUT && slot == SLOT_W'(w)) rd_mux = out_words[w];
    end
    for (int w = 0; w < int'(N_IN); w++) begin
      if (region == REG_IN && slot == SLOT_W'(w)) rd_mux = in_words[w];
    end
  end

  always_comb begin
    ready_d = accept;
    rdata_d = (accept && !bus_write) ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      ready_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      ready_q <= ready_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_ready = ready_q;
  assign bus_rdata = rdata_q;

  mbx_out_bank #(
    .N_OUT  (N_OUT),
    .SLOT_W (SLOT_W),
    .IDX_W  (IDX_W)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .we_i      (out_we),
    .slot_i    (slot),
    .wdata_i   (bus_wdata),
    .words_o   (out_words),
    .rd_idx_i  (eng_rd_idx),
    .rd_byte_o (eng_rd_data)
  );

  mbx_in_bank #(
    .N_IN      (N_IN),
    .IDX_W     (IDX_W),
    .INT_BYTES (INT_BYTES)
  ) u_in (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_en_i   (eng_wr_en),
    .wr_idx_i  (eng_wr_idx),
    .wr_data_i (eng_wr_data),
    .words_o   (in_words),
    .irq_o     (proc_irq)
  );

  mbx_doorbell u_db (
    .clk   (clk),
    .rst_n (rst_n_int),
    .set_i (db_set),
    .clr_i (eng_read_done),
    .irq_o (ext_irq)
  );

  AST_READY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n_int)
    bus_ready |-> $past(bus_valid)); // R2
  AST_OUT_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n_int)
    (region == REG_OUT) |-> (slot < SLOT_W'(N_OUT))); // R3
  AST_IN_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n_int)
    (region == REG_IN) |-> (slot < SLOT_W'(N_IN))); // R6
endmodule

// File: tb/mbx_regfile_test.sv
`timescale 1ns/1ps
module mbx_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic        eng_wr_en;
  logic [3:0]  eng_wr_idx;
  logic [7:0]  eng_wr_data;
  logic [3:0]  eng_rd_idx;
  logic [7:0]  eng_rd_data;
  logic        eng_read_done;
  logic        ext_irq, proc_irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mbx_regfile uut (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .eng_wr_en(eng_wr_en), .eng_wr_idx(eng_wr_idx), .eng_wr_data(eng_wr_data),
    .eng_rd_idx(eng_rd_idx), .eng_rd_data(eng_rd_data),
    .eng_read_done(eng_read_done), .ext_irq(ext_irq), .proc_irq(proc_irq)
  );

  // {write, addr, wdata, expected rdata (reads only), expected ext_irq}
  localparam int NV = 11;
  localparam logic [73:0] VECS [NV] = '{
    {1'b1, 8'h04, 32'hA1B2C3D4, 32'h0,        1'b0},  // R3 R4
    {1'b1, 8'h08, 32'h55667788, 32'h0,        1'b0},  // R3 R4
    {1'b0, 8'h04, 32'h0,        32'hA1B2C3D4, 1'b0},  // R3
    {1'b0, 8'h08, 32'h0,        32'h55667788, 1'b0},  // R3
    {1'b1, 8'h0C, 32'hDEADBEEF, 32'h0,        1'b0},  // R6
    {1'b0, 8'h0C, 32'h0,        32'h00000000, 1'b0},  // R6
    {1'b0, 8'h18, 32'h0,        32'h00000000, 1'b0},  // R9
    {1'b0, 8'hFC, 32'h0,        32'h00000000, 1'b0},  // R9
    {1'b1, 8'h00, 32'hCAFEF00D, 32'h0,        1'b1},  // R4
    {1'b0, 8'h00, 32'h0,        32'hCAFEF00D, 1'b1},  // R3
    {1'b0, 8'h05, 32'h0,        32'hA1B2C3D4, 1'b1}   // R3 low bits ignored
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_xfer(input logic wr, input logic [7:0] a, input logic [31:0] d,
                          output logic [31:0] rd);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    chk("R2 ready after accept", {31'b0, bus_ready}, 32'd1);
    rd = bus_rdata;
    bus_valid = 1'b0; bus_write = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R2 ready one cycle", {31'b0, bus_ready}, 32'd0);
  endtask

  task automatic eng_write(input logic [3:0] idx, input logic [7:0] d);
    @(negedge clk);
    eng_wr_en = 1'b1; eng_wr_idx = idx; eng_wr_data = d;
    @(posedge clk);
    @(negedge clk);
    eng_wr_en = 1'b0;
    chk($sformatf("R8 proc_irq idx %0d", idx), {31'b0, proc_irq}, {31'b0, idx == 4'd11});
  endtask

  task automatic read_done_pulse();
    @(negedge clk);
    eng_read_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    eng_read_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    eng_wr_en = 1'b0; eng_wr_idx = '0; eng_wr_data = '0; eng_rd_idx = '0;
    eng_read_done = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {31'b0, bus_ready}, 32'd0);
    chk("R1 ext_irq in reset", {31'b0, ext_irq}, 32'd0);
    chk("R1 proc_irq in reset", {31'b0, proc_irq}, 32'd0);
    chk("R1 eng_rd_data in reset", {24'b0, eng_rd_data}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int w = 0; w < 6; w++) begin
      bus_xfer(1'b0, 8'(w * 4), 32'h0, rd);
      chk($sformatf("R1 word %0d after reset", w), rd, 32'h0);
    end

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [73:0] v;
      v = VECS[i];
      bus_xfer(v[73], v[72:65], v[64:33], rd);
      if (!v[73]) chk($sformatf("R3/R6/R9 vector %0d rdata", i), rd, v[32:1]);
      chk($sformatf("R4 vector %0d ext_irq", i), {31'b0, ext_irq}, {31'b0, v[0]});
    end

    // R10 engine-side byte view of outbound words
    begin
      logic [7:0] exp_b [16];
      logic [95:0] ow;
      ow = {32'h55667788, 32'hA1B2C3D4, 32'hCAFEF00D};
      for (int b = 0; b < 16; b++) exp_b[b] = (b < 12) ? ow[b*8 +: 8] : 8'h00;
      for (int b = 0; b < 16; b++) begin
        @(negedge clk);
        eng_rd_idx = 4'(b);
        #1;
        chk($sformatf("R10 eng byte %0d", b), {24'b0, eng_rd_data}, {24'b0, exp_b[b]});
      end
    end

    // R5 clear, hold, then simultaneous set/clear
    read_done_pulse();
    chk("R5 clear by read done", {31'b0, ext_irq}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R5 stays low", {31'b0, ext_irq}, 32'd0);
    bus_xfer(1'b1, 8'h08, 32'h01020304, rd);
    chk("R4 word2 write no irq", {31'b0, ext_irq}, 32'd0);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h0BADC0DE;
    eng_read_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; eng_read_done = 1'b0;
    chk("R5 set wins over clear", {31'b0, ext_irq}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R5 holds high", {31'b0, ext_irq}, 32'd1);

    // R7 / R8 inbound bytes
    for (int b = 0; b < 12; b++) eng_write(4'(b), 8'(8'h10 + b));
    bus_xfer(1'b0, 8'h0C, 32'h0, rd); chk("R7 inbound word0", rd, 32'h13121110);
    bus_xfer(1'b0, 8'h10, 32'h0, rd); chk("R7 inbound word1", rd, 32'h17161514);
    bus_xfer(1'b0, 8'h14, 32'h0, rd); chk("R7 inbound word2", rd, 32'h1B1A1918);
    eng_write(4'd11, 8'hEE);
    @(negedge clk);
    chk("R8 pulse is one cycle", {31'b0, proc_irq}, 32'd0);
    eng_write(4'd5, 8'hA5);
    bus_xfer(1'b0, 8'h10, 32'h0, rd); chk("R7 single lane update", rd, 32'h1716A514);

    // R6 write to inbound ignored; R11 reads do not disturb
    bus_xfer(1'b1, 8'h10, 32'hFFFFFFFF, rd);
    bus_xfer(1'b0, 8'h10, 32'h0, rd); chk("R6 write to inbound ignored", rd, 32'h1716A514);
    bus_xfer(1'b0, 8'h10, 32'h0, rd); chk("R11 reread inbound", rd, 32'h1716A514);
    bus_xfer(1'b0, 8'h14, 32'h0, rd); chk("R11 reread inbound word2", rd, 32'hEE1A1918);
    bus_xfer(1'b0, 8'h00, 32'h0, rd); chk("R11 reread outbound", rd, 32'h0BADC0DE);
    chk("R5 read does not clear", {31'b0, ext_irq}, 32'd1);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 ext_irq cleared by reset", {31'b0, ext_irq}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_xfer(1'b0, 8'h00, 32'h0, rd); chk("R1 outbound cleared", rd, 32'h0);
    bus_xfer(1'b0, 8'h0C, 32'h0, rd); chk("R1 inbound cleared", rd, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule